// File: doc/BRIEF.md
# Signed Multi-Operand Reduction Adder

This block adds up the partial products coming from a row of shift-based multipliers and returns one signed dot-product value per input beat. Each multiplier unit supplies three unsigned magnitudes. Each magnitude has a subtract flag and an enable bit. The block sums all of them in a single pass through a carry-save compressor tree. A carry-lookahead adder then resolves the remaining pair of rows, and the result is registered once at the output.

Subtraction costs no sign-extension. A flagged magnitude enters the tree bit-inverted at its own narrow width. The number of flagged operands is folded into one correction word, which is added in a last compressor row placed just ahead of the final adder. Compressor widths grow by one bit per tree level and stop at the output width. The output width is the magnitude width plus the bits needed to count the operands, plus one sign bit.

A caller presents the operand vector together with `in_valid`. The matching sum appears on `out_sum` one clock later, with `out_valid` raised.

Top module: `mor_reduce_adder`

## Requirements
- R1: One cycle after a beat with `in_valid` high, `out_sum` equals the signed total over all enabled operands. Operand k uses magnitude `op_mag[k*MAG_W +: MAG_W]`, subtract flag `op_neg[k]` and enable `op_en[k]`. A set flag subtracts the magnitude and a clear flag adds it. The total is given as a two's-complement value of `MAG_W + clog2(N_UNITS*OPS_PER_UNIT) + 1` bits (21 bits by default).
- R2: `out_valid` is the value of `in_valid` from the previous clock. While `rst_n` is low, `out_valid` and `out_sum` are both 0.
- R3: An operand whose enable bit is 0 adds nothing to the total, whatever its magnitude and subtract flag.
- R4: If every enabled operand has magnitude zero, or no operand is enabled, `out_sum` is exactly 0 whatever the subtract flags are.
- R5: The two extreme cases come out exact, with no wrap. With defaults these are all 24 operands at the maximum magnitude 32767, giving +786408, and the same with every flag set, giving -786408.
- R6: After a beat with `in_valid` low, `out_sum` keeps its previous value even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand vector is valid this cycle |
| op_mag | input | N_UNITS*OPS_PER_UNIT*MAG_W | Packed operand magnitudes, operand k at bits k*MAG_W upward |
| op_neg | input | N_UNITS*OPS_PER_UNIT | Subtract flag per operand |
| op_en | input | N_UNITS*OPS_PER_UNIT | Enable per operand |
| out_valid | output | 1 | Registered sum is fresh |
| out_sum | output | MAG_W+clog2(N_UNITS*OPS_PER_UNIT)+1 | Registered two's-complement total |

## Verification
The checker assumes the operand inputs are meaningful only in a cycle where `in_valid` is high. It also assumes the worst-case total, every operand at full magnitude with one sign, never exceeds the declared output range. That range is guaranteed by the output width formula, so any bit pattern on the inputs is legal. The stimulus therefore ranges freely over magnitudes, flags and enables. It uses directed extremes: all operands at maximum, all operands flagged, zero magnitudes with flags set, and disabled operands carrying full-scale values. These are followed by random vectors and by idle cycles in which the inputs move while `in_valid` stays low.

// File: rtl/mor_pkg.sv
package mor_pkg;

   // Operand count after one 3:2 compressor level: every full triple becomes two rows.
   function automatic int next_count(input int c);
      return 2 * (c / 3) + (c % 3);
   endfunction

   // Row count entering level l of a tree that starts with n rows.
   function automatic int count_at(input int n, input int l);
      int c;
      c = n;
      for (int i = 0; i < l; i++) c = next_count(c);
      return c;
   endfunction

   // Levels needed to bring n rows down to at most two.
   function automatic int level_total(input int n);
      int c;
      int l;
      c = n;
      l = 0;
      while (c > 2) begin
         c = next_count(c);
         l++;
      end
      return l;
   endfunction

   // Row width at level l: one bit per level above the base, capped at the output width.
   function automatic int width_at(input int base, input int l, input int cap);
      return (base + l > cap) ? cap : base + l;
   endfunction

endpackage

// File: rtl/mor_operand_prep.sv
module mor_operand_prep #(
   parameter int NUM_OPS = 24,
   parameter int MAG_W   = 15,
   parameter int OUT_W   = 21
) (
   input  logic [NUM_OPS*MAG_W-1:0] op_mag,
   input  logic [NUM_OPS-1:0]       op_neg,
   input  logic [NUM_OPS-1:0]       op_en,
   output logic [MAG_W-1:0]         rows_o [NUM_OPS],
   output logic [OUT_W-1:0]         corr_o
);
   localparam int CNT_W = $clog2(NUM_OPS + 1);

   logic [NUM_OPS-1:0] sub_act;
   logic [CNT_W-1:0]   sub_cnt;
   logic [OUT_W-1:0]   cnt_w;

   assign sub_act = op_neg & op_en;

   // Disabled rows are forced to zero; subtracted rows are inverted at native width.
   for (genvar k = 0; k < NUM_OPS; k++) begin : g_row
      assign rows_o[k] = op_en[k] ? (op_mag[k*MAG_W +: MAG_W] ^ {MAG_W{sub_act[k]}})
                                  : '0;
   end

   always_comb begin
      sub_cnt = '0;
      for (int k = 0; k < NUM_OPS; k++) sub_cnt = sub_cnt + CNT_W'(sub_act[k]);
   end

   // Each inverted row lacks (+1) and carries an implicit -(2^MAG_W) in its sign part.
   assign cnt_w  = OUT_W'(sub_cnt);
   assign corr_o = cnt_w - (cnt_w << MAG_W);

endmodule

// File: rtl/mor_csa.sv
module mor_csa #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s,
   output logic [W-1:0] cy
);
   assign s  = a ^ b ^ c;
   // Carry leaves the top bit: at the cap this is the modular wrap, below it that bit is zero.
   assign cy = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]), 1'b0};
endmodule

// File: rtl/mor_cla.sv
module mor_cla #(
   parameter int W = 21
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   localparam int STG = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0] gg [STG+1];
   logic [W-1:0] pp [STG+1];

   assign gg[0] = a & b;
   assign pp[0] = a ^ b;

   // Parallel-prefix carry lookahead: span doubles each stage.
   for (genvar s = 1; s <= STG; s++) begin : g_stage
      localparam int D = 1 << (s - 1);
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i >= D) begin : g_merge
            assign gg[s][i] = gg[s-1][i] | (pp[s-1][i] & gg[s-1][i-D]);
            assign pp[s][i] = pp[s-1][i] & pp[s-1][i-D];
         end else begin : g_pass
            assign gg[s][i] = gg[s-1][i];
            assign pp[s][i] = pp[s-1][i];
         end
      end
   end

   assign sum[0] = pp[0][0];
   for (genvar i = 1; i < W; i++) begin : g_sum
      assign sum[i] = pp[0][i] ^ gg[STG][i-1];
   end

endmodule

// File: rtl/mor_reduce_adder.sv
module mor_reduce_adder #(
   parameter int N_UNITS      = 8,
   parameter int OPS_PER_UNIT = 3,
   parameter int MAG_W        = 15,
   localparam int NUM_OPS     = N_UNITS * OPS_PER_UNIT,
   localparam int OUT_W       = MAG_W + $clog2(NUM_OPS) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [NUM_OPS*MAG_W-1:0] op_mag,
   input  logic [NUM_OPS-1:0]       op_neg,
   input  logic [NUM_OPS-1:0]       op_en,
   output logic                     out_valid,
   output logic [OUT_W-1:0]         out_sum
);
   import mor_pkg::*;

   localparam int LVLS   = level_total(NUM_OPS);
   localparam int LAST_C = count_at(NUM_OPS, LVLS);

   if (N_UNITS < 1)      begin : g_chk_units $error("N_UNITS must be at least 1"); end
   if (OPS_PER_UNIT < 1) begin : g_chk_ops   $error("OPS_PER_UNIT must be at least 1"); end
   if (MAG_W < 2)        begin : g_chk_mag   $error("MAG_W must be at least 2"); end

   logic [MAG_W-1:0] rows  [NUM_OPS];
   logic [OUT_W-1:0] corr;
   logic [OUT_W-1:0] lvl   [LVLS+1][NUM_OPS];
   logic [OUT_W-1:0] fin_a;
   logic [OUT_W-1:0] fin_b;
   logic [OUT_W-1:0] fin_s;
   logic [OUT_W-1:0] fin_c;
   logic [OUT_W-1:0] sum_w;

   mor_operand_prep #(.NUM_OPS(NUM_OPS), .MAG_W(MAG_W), .OUT_W(OUT_W)) u_prep (
      .op_mag (op_mag),
      .op_neg (op_neg),
      .op_en  (op_en),
      .rows_o (rows),
      .corr_o (corr)
   );

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_l0
      assign lvl[0][k] = OUT_W'(rows[k]);
   end

   // Wallace levels: full triples compress, leftovers pass through, widths grow by one.
   for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
      localparam int PC = count_at(NUM_OPS, l - 1);
      localparam int NC = count_at(NUM_OPS, l);
      localparam int G  = PC / 3;
      localparam int R  = PC % 3;
      localparam int WL = width_at(MAG_W, l, OUT_W);
      for (genvar g = 0; g < G; g++) begin : g_grp
         logic [WL-1:0] s_g;
         logic [WL-1:0] c_g;
         mor_csa #(.W(WL)) u_csa (
            .a  (lvl[l-1][3*g][WL-1:0]),
            .b  (lvl[l-1][3*g+1][WL-1:0]),
            .c  (lvl[l-1][3*g+2][WL-1:0]),
            .s  (s_g),
            .cy (c_g)
         );
         assign lvl[l][2*g]   = OUT_W'(s_g);
         assign lvl[l][2*g+1] = OUT_W'(c_g);
      end
      for (genvar r = 0; r < R; r++) begin : g_pass
         assign lvl[l][2*G+r] = lvl[l-1][3*G+r];
      end
      for (genvar k = NC; k < NUM_OPS; k++) begin : g_idle
         assign lvl[l][k] = '0;
      end
   end

   assign fin_a = lvl[LVLS][0];
   if (LAST_C >= 2) begin : g_two
      assign fin_b = lvl[LVLS][1];
   end else begin : g_one
      assign fin_b = '0;
   end

   // Correction row joins in a last full-width compressor ahead of the resolving adder.
   mor_csa #(.W(OUT_W)) u_corr_csa (
      .a  (fin_a),
      .b  (fin_b),
      .c  (corr),
      .s  (fin_s),
      .cy (fin_c)
   );

   mor_cla #(.W(OUT_W)) u_cla (
      .a   (fin_s),
      .b   (fin_c),
      .sum (sum_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sum   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sum <= sum_w;
      end
   end

endmodule

// File: rtl/mor_reduce_adder_chk.sv
module mor_reduce_adder_chk #(
   parameter int N_UNITS      = 8,
   parameter int OPS_PER_UNIT = 3,
   parameter int MAG_W        = 15,
   localparam int NUM_OPS     = N_UNITS * OPS_PER_UNIT,
   localparam int OUT_W       = MAG_W + $clog2(NUM_OPS) + 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [NUM_OPS*MAG_W-1:0] op_mag,
   input logic [NUM_OPS-1:0]       op_neg,
   input logic [NUM_OPS-1:0]       op_en,
   input logic                     out_valid,
   input logic [OUT_W-1:0]         out_sum
);
   localparam longint MAXV = longint'(NUM_OPS) * ((longint'(1) << MAG_W) - 1);

   logic [OUT_W-1:0] ref_sum;
   logic             quiet;

   always_comb begin
      longint acc;
      acc   = 0;
      quiet = 1'b1;
      for (int k = 0; k < NUM_OPS; k++) begin
         if (op_en[k]) begin
            if (op_mag[k*MAG_W +: MAG_W] != '0) quiet = 1'b0;
            if (op_neg[k]) acc = acc - longint'(op_mag[k*MAG_W +: MAG_W]);
            else           acc = acc + longint'(op_mag[k*MAG_W +: MAG_W]);
         end
      end
      ref_sum = OUT_W'(acc);
   end

   a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_sum == $past(ref_sum)));

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r4_quiet_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && quiet) |=> (out_sum == '0));

   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((longint'($signed(out_sum)) <= MAXV) &&
                     (longint'($signed(out_sum)) >= -MAXV)));

   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sum));

endmodule

bind mor_reduce_adder mor_reduce_adder_chk #(
   .N_UNITS      (N_UNITS),
   .OPS_PER_UNIT (OPS_PER_UNIT),
   .MAG_W        (MAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_mag    (op_mag),
   .op_neg    (op_neg),
   .op_en     (op_en),
   .out_valid (out_valid),
   .out_sum   (out_sum)
);

// File: tb/mor_reduce_adder_bench.sv
`timescale 1ns/1ps
module mor_reduce_adder_bench;
   localparam int N_UNITS = 8;
   localparam int OPS     = 3;
   localparam int MAG_W   = 15;
   localparam int NOPS    = 24;
   localparam int OUT_W   = 21;
   localparam longint MAXM = 32767;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   in_valid = 1'b0;
   logic [NOPS*MAG_W-1:0]  op_mag = '0;
   logic [NOPS-1:0]        op_neg = '0;
   logic [NOPS-1:0]        op_en = '0;
   logic                   out_valid;
   logic [OUT_W-1:0]       out_sum;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   mor_reduce_adder #(.N_UNITS(N_UNITS), .OPS_PER_UNIT(OPS), .MAG_W(MAG_W)) u_mor_reduce_adder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_mag    (op_mag),
      .op_neg    (op_neg),
      .op_en     (op_en),
      .out_valid (out_valid),
      .out_sum   (out_sum)
   );

   function automatic longint model();
      longint acc = 0;
      for (int k = 0; k < NOPS; k++)
         if (op_en[k]) begin
            if (op_neg[k]) acc -= longint'(op_mag[k*MAG_W +: MAG_W]);
            else           acc += longint'(op_mag[k*MAG_W +: MAG_W]);
         end
      return acc;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Present one beat, then sample the registered result at the next falling edge.
   task automatic run_one(input string req);
      longint exp;
      exp = model();
      @(negedge clk);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, longint'(out_valid), 1);
      check({req, " sum"}, longint'($signed(out_sum)), exp);
   endtask

   task automatic set_all(input logic [MAG_W-1:0] m, input logic neg, input logic en);
      for (int k = 0; k < NOPS; k++) op_mag[k*MAG_W +: MAG_W] = m;
      op_neg = {NOPS{neg}};
      op_en  = {NOPS{en}};
   endtask

   task automatic t_reset();
      check("R2 reset valid", longint'(out_valid), 0);
      check("R2 reset sum", longint'(out_sum), 0);
   endtask

   task automatic t_extremes();
      set_all('1, 1'b0, 1'b1);
      run_one("R5 all max positive");
      check("R5 max positive value", longint'($signed(out_sum)), NOPS * MAXM);
      set_all('1, 1'b1, 1'b1);
      run_one("R5 all max negative");
      check("R5 max negative value", longint'($signed(out_sum)), -NOPS * MAXM);
   endtask

   task automatic t_quiet();
      set_all('0, 1'b1, 1'b1);
      run_one("R4 zero mags flagged");
      check("R4 zero exact", longint'(out_sum), 0);
      set_all('1, 1'b1, 1'b0);
      run_one("R4 none enabled");
      check("R4 disabled exact", longint'(out_sum), 0);
      set_all('0, 1'b0, 1'b1);
      op_neg = 24'hA5C3F0;
      run_one("R4 zero mags mixed flags");
   endtask

   task automatic t_disabled();
      set_all(15'd100, 1'b0, 1'b1);
      op_mag[7*MAG_W +: MAG_W] = '1;
      op_neg[7] = 1'b1;
      op_en[7]  = 1'b0;
      op_mag[20*MAG_W +: MAG_W] = '1;
      op_en[20] = 1'b0;
      run_one("R3 disabled full-scale");
      check("R3 disabled value", longint'($signed(out_sum)), 22 * 100);
   endtask

   task automatic t_single();
      set_all('0, 1'b0, 1'b1);
      op_mag[5*MAG_W +: MAG_W] = 15'd1;
      op_neg[5] = 1'b1;
      run_one("R1 single minus one");
      check("R1 minus one value", longint'($signed(out_sum)), -1);
      set_all('0, 1'b0, 1'b1);
      op_mag[23*MAG_W +: MAG_W] = 15'd12345;
      op_mag[0 +: MAG_W] = 15'd345;
      op_neg[0] = 1'b1;
      run_one("R1 top and bottom position");
      check("R1 position value", longint'($signed(out_sum)), 12000);
   endtask

   task automatic t_random();
      for (int i = 0; i < 60; i++) begin
         for (int k = 0; k < NOPS; k++) op_mag[k*MAG_W +: MAG_W] = MAG_W'($urandom);
         op_neg = NOPS'($urandom);
         op_en  = (i % 3 == 0) ? '1 : NOPS'($urandom);
         run_one("R1 random");
      end
   endtask

   task automatic t_hold();
      longint kept;
      set_all(15'd7, 1'b1, 1'b1);
      run_one("R6 setup");
      kept = longint'($signed(out_sum));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         for (int k = 0; k < NOPS; k++) op_mag[k*MAG_W +: MAG_W] = MAG_W'($urandom);
         op_neg = NOPS'($urandom);
         op_en  = '1;
         @(negedge clk);
         check("R6 held sum", longint'($signed(out_sum)), kept);
         check("R2 idle valid low", longint'(out_valid), 0);
      end
   endtask

   task automatic t_back_to_back();
      longint e1;
      longint e2;
      @(negedge clk);
      set_all(15'd1000, 1'b0, 1'b1);
      e1 = model();
      in_valid = 1'b1;
      @(negedge clk);
      check("R2 b2b first", longint'($signed(out_sum)), e1);
      set_all(15'd3, 1'b1, 1'b1);
      e2 = model();
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 b2b valid", longint'(out_valid), 1);
      check("R2 b2b second", longint'($signed(out_sum)), e2);
      @(negedge clk);
      check("R2 b2b valid drops", longint'(out_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_extremes();
      t_quiet();
      t_disabled();
      t_single();
      t_random();
      t_hold();
      t_back_to_back();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule